// File: doc/BRIEF.md
# Privileged Segment Decoder with Fault Encoder

This block takes one 32-bit virtual address per request and sorts it into one of five fixed regions of the address space. The privilege level (kernel, supervisor or user) and an error-level flag decide how each region is treated. An address that may bypass translation gets its physical address directly from a fixed offset. An address that needs translation is passed to an attached lookup table, which answers combinationally in the same cycle. An access that the current privilege may not make ends as an address fault.

When the final outcome is a fault, the block turns it into an exception cause code, plus a refill flag and an instruction-not-available flag. In the same clock edge it records the faulting address in three system registers: the bad-address register, the context register and the entry-high register. The context and entry-high registers can also be loaded through a small write port. The low byte of entry-high is the current address-space identifier that the lookup table compares against.

Results are registered. The response for a request appears exactly one cycle after the request is presented.

Top module: `vseg_xlate`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid`, `rsp_fault`, `bad_vaddr`, `context_reg` and `entry_hi` are all zero.
- R2: An address with bit 31 clear, presented while `err_level` is 1, translates to itself without a fault. In that case `tlb_req` stays low and `tlb_result` has no effect.
- R3: `tlb_req` is high, and the physical address on a hit (`tlb_result` 0) is `tlb_paddr`, in three cases: an address with bit 31 clear while `err_level` is 0; addresses 0xC0000000–0xDFFFFFFF for supervisor or kernel; addresses from 0xE0000000 up for kernel. In every other case `tlb_req` is low.
- R4: For kernel access, addresses 0x80000000–0x9FFFFFFF give the address minus 0x80000000, and addresses 0xA0000000–0xBFFFFFFF give the address minus 0xA0000000. These addresses never consult the lookup table.
- R5: The `priv_mode` encoding is 1 = supervisor, 2 = user, 0 or 3 = kernel. The two unmapped regions and the region from 0xE0000000 up are kernel-only. The region 0xC0000000–0xDFFFFFFF denies only user access. A denied access is an address fault.
- R6: The `req_kind` encoding is 0 = load, 1 = store, 2 = instruction fetch. An address fault gives cause code 5 for a store and 4 otherwise.
- R7: The `tlb_result` encoding is 0 = hit, 1 = no match, 2 = entry invalid, 3 = write to a clean page, 4 = execute inhibited, 5 = read inhibited; 6 and 7 are treated as no match. No match and invalid give cause code 3 for a store and 2 otherwise. `rsp_refill` is 1 only for no match.
- R8: A write to a clean page gives cause code 1. Execute-inhibit gives 20 and read-inhibit gives 19 when `inhibit_exc_en` is 1; both give 2 when it is 0.
- R9: `rsp_inst_na` is 1 exactly on faults of fetch requests.
- R10: `rsp_valid` pulses in the cycle after each request and at no other time. On a fault, `rsp_paddr` is 0. Without a fault, `rsp_exc_code`, `rsp_refill` and `rsp_inst_na` are 0.
- R11: A fault updates three registers at the same edge as its response:
  - `bad_vaddr` takes the full address.
  - `context_reg` keeps bits 31:23, takes address bits 31:13 into bits 22:4, and clears bits 3:0.
  - `entry_hi` takes address bits 31:13 into bits 31:13, clears bits 12:8, and keeps bits 7:0.
  A request without a fault changes none of the three.
- R12: When `sys_wr_en` is 1, the register selected by `sys_wr_sel` (0 = context, 1 = entry-high) is loaded with `sys_wr_data`. A faulting request in the same cycle takes priority and the write is dropped. `tlb_asid` always shows `entry_hi` bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| priv_mode | input | 2 | Privilege: 1 supervisor, 2 user, else kernel |
| err_level | input | 1 | Error-level flag |
| inhibit_exc_en | input | 1 | Enables the dedicated read/execute-inhibit cause codes |
| tlb_req | output | 1 | Lookup table consulted for this request |
| tlb_vaddr | output | 32 | Address presented to the lookup table |
| tlb_asid | output | 8 | Current address-space identifier |
| tlb_result | input | 3 | Lookup outcome code |
| tlb_paddr | input | 32 | Physical address on a hit |
| sys_wr_en | input | 1 | System register write strobe |
| sys_wr_sel | input | 1 | 0 context, 1 entry-high |
| sys_wr_data | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Response is a fault |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_exc_code | output | 5 | Exception cause code |
| rsp_refill | output | 1 | Fault came from a missing mapping |
| rsp_inst_na | output | 1 | Fault on an instruction fetch |
| bad_vaddr | output | 32 | Last faulting address |
| context_reg | output | 32 | Context register |
| entry_hi | output | 32 | Entry-high register |

## Verification
Some properties are checked by assertions on every cycle:
- responses only ever follow requests, and a fault response carries a zero physical address;
- user-mode requests into the upper half never reach the lookup table;
- the refill and instruction-not-available flags appear only on fitting faults;
- a fault records the previous cycle's address while keeping the identifier byte;
- a successful response leaves the bad-address register unchanged.

The bench scenarios cover what needs exact values. These are the cause codes for each access kind and lookup outcome with the inhibit enable on and off, the offset arithmetic at both ends of the unmapped regions, and the region edges at 0x7FFFFFFF, 0xC0000000, 0xDFFFFFFF and 0xE0000000. The scenarios also cover the bit-field composition of the context and entry-high registers, and a system write that collides with a fault.

// File: rtl/vseg_pkg.sv
// Shared widths, encodings and the decoded-segment record for the
// privileged segment decoder. Assumes 4 KiB pages mapped in even/odd pairs.
package vseg_pkg;
    localparam int VA_W       = 32;
    localparam int ASID_W     = 8;
    localparam int EXC_W      = 5;
    localparam int PAIR_SHIFT = 13;
    localparam int CTX_LO     = 4;
    localparam int CTX_HI     = CTX_LO + VA_W - PAIR_SHIFT - 1;
    localparam int REGION_W   = 3;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        TR_HIT     = 3'd0,
        TR_MISS    = 3'd1,
        TR_INVALID = 3'd2,
        TR_CLEAN   = 3'd3,
        TR_XINH    = 3'd4,
        TR_RINH    = 3'd5,
        TR_RSV6    = 3'd6,
        TR_RSV7    = 3'd7
    } tres_e;

    localparam logic [EXC_W-1:0] EXC_NONE   = 5'd0;
    localparam logic [EXC_W-1:0] EXC_MODIFY = 5'd1;
    localparam logic [EXC_W-1:0] EXC_TLB_LD = 5'd2;
    localparam logic [EXC_W-1:0] EXC_TLB_ST = 5'd3;
    localparam logic [EXC_W-1:0] EXC_ADR_LD = 5'd4;
    localparam logic [EXC_W-1:0] EXC_ADR_ST = 5'd5;
    localparam logic [EXC_W-1:0] EXC_RINH   = 5'd19;
    localparam logic [EXC_W-1:0] EXC_XINH   = 5'd20;

    typedef struct packed {
        logic            direct;
        logic            mapped;
        logic            denied;
        logic [VA_W-1:0] pa;
    } seg_dec_t;
endpackage

// File: rtl/vseg_decode.sv
// Region classifier: decides from the address, privilege and error-level flag
// whether an access is unmapped (with its physical address), needs the
// lookup table, or is denied. Purely combinational; assumes 32-bit addresses.
module vseg_decode
    import vseg_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    input  logic [1:0]      priv,
    input  logic            err_level,
    output seg_dec_t        dec
);
    localparam logic [REGION_W-1:0] RG_CACHED   = 3'b100;
    localparam logic [REGION_W-1:0] RG_UNCACHED = 3'b101;
    localparam logic [REGION_W-1:0] RG_SUPER    = 3'b110;

    logic                is_kern;
    logic                is_sup;
    logic [REGION_W-1:0] region;
    logic [VA_W-1:0]     low_pa;

    // Privilege and region fields used by the classification below.
    always_comb begin
        is_sup  = (priv == 2'd1);
        is_kern = (priv != 2'd1) && (priv != 2'd2);
        region  = vaddr[VA_W-1 -: REGION_W];
        low_pa  = {{REGION_W{1'b0}}, vaddr[VA_W-REGION_W-1:0]};
    end

    // Classify the address into direct, mapped or denied.
    always_comb begin
        dec = '0;
        if (!vaddr[VA_W-1]) begin
            if (err_level) begin
                dec.direct = 1'b1;
                dec.pa     = vaddr;
            end else begin
                dec.mapped = 1'b1;
            end
        end else if (region == RG_CACHED || region == RG_UNCACHED) begin
            dec.direct = is_kern;
            dec.denied = !is_kern;
            dec.pa     = is_kern ? low_pa : '0;
        end else if (region == RG_SUPER) begin
            dec.mapped = is_kern || is_sup;
            dec.denied = !(is_kern || is_sup);
        end else begin
            dec.mapped = is_kern;
            dec.denied = !is_kern;
        end
    end
endmodule

// File: rtl/vseg_fault_map.sv
// Outcome encoder: turns a denied access or a lookup-table result into a
// fault flag, a cause code and the refill / instruction-not-available flags.
// Combinational; assumes the decoder's denied and mapped are exclusive.
module vseg_fault_map
    import vseg_pkg::*;
(
    input  logic             denied,
    input  logic             mapped,
    input  tres_e            tres,
    input  acc_e             kind,
    input  logic             inh_en,
    output logic             fault,
    output logic [EXC_W-1:0] code,
    output logic             refill,
    output logic             inst_na
);
    logic is_store;

    // Pick the cause code for whichever failure applies.
    always_comb begin
        is_store = (kind == ACC_STORE);
        fault    = 1'b0;
        code     = EXC_NONE;
        refill   = 1'b0;
        if (denied) begin
            fault = 1'b1;
            code  = is_store ? EXC_ADR_ST : EXC_ADR_LD;
        end else if (mapped) begin
            case (tres)
                TR_HIT: fault = 1'b0;
                TR_INVALID: begin
                    fault = 1'b1;
                    code  = is_store ? EXC_TLB_ST : EXC_TLB_LD;
                end
                TR_CLEAN: begin
                    fault = 1'b1;
                    code  = EXC_MODIFY;
                end
                TR_XINH: begin
                    fault = 1'b1;
                    code  = inh_en ? EXC_XINH : EXC_TLB_LD;
                end
                TR_RINH: begin
                    fault = 1'b1;
                    code  = inh_en ? EXC_RINH : EXC_TLB_LD;
                end
                default: begin
                    fault  = 1'b1;
                    refill = 1'b1;
                    code   = is_store ? EXC_TLB_ST : EXC_TLB_LD;
                end
            endcase
        end
        inst_na = fault && (kind == ACC_FETCH);
    end
endmodule

// File: rtl/vseg_sysregs.sv
// Bad-address, context and entry-high registers. A fault capture merges the
// faulting address into them; otherwise a system write loads one register.
// Capture wins over a same-cycle write. Synchronous active-low reset.
module vseg_sysregs
    import vseg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [VA_W-1:0] vaddr,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [VA_W-1:0] wr_data,
    output logic [VA_W-1:0] bad_q,
    output logic [VA_W-1:0] ctx_q,
    output logic [VA_W-1:0] ehi_q
);
    logic [VA_W-1:0] ctx_cap;
    logic [VA_W-1:0] ehi_cap;

    // Compose the captured register images from the faulting address.
    always_comb begin
        ctx_cap = {ctx_q[VA_W-1:CTX_HI+1], vaddr[VA_W-1:PAIR_SHIFT], {CTX_LO{1'b0}}};
        ehi_cap = {vaddr[VA_W-1:PAIR_SHIFT], {(PAIR_SHIFT-ASID_W){1'b0}}, ehi_q[ASID_W-1:0]};
    end

    // Update the three registers: reset, fault capture, or system write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_q <= '0;
            ctx_q <= '0;
            ehi_q <= '0;
        end else if (capture) begin
            bad_q <= vaddr;
            ctx_q <= ctx_cap;
            ehi_q <= ehi_cap;
        end else if (wr_en) begin
            if (wr_sel) ehi_q <= wr_data;
            else        ctx_q <= wr_data;
        end
    end
endmodule

// File: rtl/vseg_xlate.sv
// Top of the privileged segment decoder. Consults an attached lookup table
// that answers in the same cycle, registers the response one cycle after
// the request, and captures faulting addresses into the system registers.
module vseg_xlate
    import vseg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [31:0]      req_vaddr,
    input  logic [1:0]       req_kind,
    input  logic [1:0]       priv_mode,
    input  logic             err_level,
    input  logic             inhibit_exc_en,
    output logic             tlb_req,
    output logic [31:0]      tlb_vaddr,
    output logic [7:0]       tlb_asid,
    input  logic [2:0]       tlb_result,
    input  logic [31:0]      tlb_paddr,
    input  logic             sys_wr_en,
    input  logic             sys_wr_sel,
    input  logic [31:0]      sys_wr_data,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [31:0]      rsp_paddr,
    output logic [4:0]       rsp_exc_code,
    output logic             rsp_refill,
    output logic             rsp_inst_na,
    output logic [31:0]      bad_vaddr,
    output logic [31:0]      context_reg,
    output logic [31:0]      entry_hi
);
    seg_dec_t         dec;
    logic             f_fault;
    logic [EXC_W-1:0] f_code;
    logic             f_refill;
    logic             f_inst_na;
    logic [VA_W-1:0]  final_pa;

    vseg_decode u_decode (
        .vaddr     (req_vaddr),
        .priv      (priv_mode),
        .err_level (err_level),
        .dec       (dec)
    );

    vseg_fault_map u_fmap (
        .denied  (dec.denied),
        .mapped  (dec.mapped),
        .tres    (tres_e'(tlb_result)),
        .kind    (acc_e'(req_kind)),
        .inh_en  (inhibit_exc_en),
        .fault   (f_fault),
        .code    (f_code),
        .refill  (f_refill),
        .inst_na (f_inst_na)
    );

    vseg_sysregs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (req_valid && f_fault),
        .vaddr   (req_vaddr),
        .wr_en   (sys_wr_en),
        .wr_sel  (sys_wr_sel),
        .wr_data (sys_wr_data),
        .bad_q   (bad_vaddr),
        .ctx_q   (context_reg),
        .ehi_q   (entry_hi)
    );

    // Lookup-table request side.
    always_comb begin
        tlb_req   = req_valid && dec.mapped;
        tlb_vaddr = req_vaddr;
        tlb_asid  = entry_hi[ASID_W-1:0];
        final_pa  = dec.mapped ? tlb_paddr : dec.pa;
    end

    // Response register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_fault    <= 1'b0;
            rsp_paddr    <= '0;
            rsp_exc_code <= '0;
            rsp_refill   <= 1'b0;
            rsp_inst_na  <= 1'b0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_fault    <= req_valid && f_fault;
            rsp_paddr    <= (req_valid && !f_fault) ? final_pa : '0;
            rsp_exc_code <= req_valid ? f_code : EXC_NONE;
            rsp_refill   <= req_valid && f_refill;
            rsp_inst_na  <= req_valid && f_inst_na;
        end
    end

    assert_resp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    assert_fault_zero_pa_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && rsp_paddr == '0));

    assert_user_no_upper_lookup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv_mode == 2'd2 && req_vaddr[31]) |-> !tlb_req);

    assert_refill_on_tlb_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_refill |-> (rsp_fault && (rsp_exc_code == EXC_TLB_LD || rsp_exc_code == EXC_TLB_ST)));

    assert_inst_na_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_inst_na |-> (rsp_fault && $past(req_kind) == 2'd2));

    assert_badaddr_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (bad_vaddr == $past(req_vaddr)));

    assert_asid_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (entry_hi[ASID_W-1:0] == $past(entry_hi[ASID_W-1:0])));

    assert_ok_badaddr_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> $stable(bad_vaddr));
endmodule

// File: tb/vseg_xlate_test.sv
// Scoreboard bench: the driver computes each expected response from the
// requirements and queues it; the monitor pops and compares after each edge.
module vseg_xlate_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        fault;
        logic [31:0] pa;
        logic [4:0]  code;
        logic        refill;
        logic        ina;
        logic [31:0] bad;
        logic [31:0] ctx;
        logic [31:0] ehi;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  priv_mode = '0;
    logic        err_level = 1'b0;
    logic        inhibit_exc_en = 1'b0;
    logic        tlb_req;
    logic [31:0] tlb_vaddr;
    logic [7:0]  tlb_asid;
    logic [2:0]  tlb_result = '0;
    logic [31:0] tlb_paddr = '0;
    logic        sys_wr_en = 1'b0;
    logic        sys_wr_sel = 1'b0;
    logic [31:0] sys_wr_data = '0;
    logic        rsp_valid, rsp_fault, rsp_refill, rsp_inst_na;
    logic [31:0] rsp_paddr, bad_vaddr, context_reg, entry_hi;
    logic [4:0]  rsp_exc_code;

    int n_vec = 0;
    int n_bad = 0;
    exp_t sb[$];
    logic [31:0] m_bad = '0, m_ctx = '0, m_ehi = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vseg_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .priv_mode(priv_mode), .err_level(err_level),
        .inhibit_exc_en(inhibit_exc_en), .tlb_req(tlb_req), .tlb_vaddr(tlb_vaddr),
        .tlb_asid(tlb_asid), .tlb_result(tlb_result), .tlb_paddr(tlb_paddr),
        .sys_wr_en(sys_wr_en), .sys_wr_sel(sys_wr_sel), .sys_wr_data(sys_wr_data),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_exc_code(rsp_exc_code), .rsp_refill(rsp_refill), .rsp_inst_na(rsp_inst_na),
        .bad_vaddr(bad_vaddr), .context_reg(context_reg), .entry_hi(entry_hi)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one request (optionally with a system write) per call.
    task automatic apply(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] priv,
                         input logic el, input logic ie, input logic [2:0] tr, input logic [31:0] tpa,
                         input logic wen, input logic wsel, input logic [31:0] wdata, input string tag);
        exp_t e;
        logic kern, sup, mapped, denied, st;
        logic [31:0] dpa;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; priv_mode = priv;
        err_level = el; inhibit_exc_en = ie; tlb_result = tr; tlb_paddr = tpa;
        sys_wr_en = wen; sys_wr_sel = wsel; sys_wr_data = wdata;
        kern = (priv == 2'd0) || (priv == 2'd3);
        sup = (priv == 2'd1);
        st = (kind == 2'd1);
        mapped = 1'b0; denied = 1'b0; dpa = '0;
        if (!va[31]) begin
            if (el) dpa = va; else mapped = 1'b1;
        end else if (va < 32'hA000_0000) begin
            if (kern) dpa = va - 32'h8000_0000; else denied = 1'b1;
        end else if (va < 32'hC000_0000) begin
            if (kern) dpa = va - 32'hA000_0000; else denied = 1'b1;
        end else if (va < 32'hE000_0000) begin
            if (kern || sup) mapped = 1'b1; else denied = 1'b1;
        end else begin
            if (kern) mapped = 1'b1; else denied = 1'b1;
        end
        e.fault = 1'b0; e.code = 5'd0; e.refill = 1'b0; e.pa = dpa; e.tag = tag;
        if (denied) begin
            e.fault = 1'b1; e.code = st ? 5'd5 : 5'd4;
        end else if (mapped) begin
            case (tr)
                3'd0: e.pa = tpa;
                3'd2: begin e.fault = 1'b1; e.code = st ? 5'd3 : 5'd2; end
                3'd3: begin e.fault = 1'b1; e.code = 5'd1; end
                3'd4: begin e.fault = 1'b1; e.code = ie ? 5'd20 : 5'd2; end
                3'd5: begin e.fault = 1'b1; e.code = ie ? 5'd19 : 5'd2; end
                default: begin e.fault = 1'b1; e.refill = 1'b1; e.code = st ? 5'd3 : 5'd2; end
            endcase
        end
        if (e.fault) e.pa = '0;
        e.ina = e.fault && (kind == 2'd2);
        if (e.fault) begin
            m_bad = va;
            m_ctx = {m_ctx[31:23], va[31:13], 4'b0000};
            m_ehi = {va[31:13], 5'b00000, m_ehi[7:0]};
        end else if (wen) begin
            if (wsel) m_ehi = wdata; else m_ctx = wdata;
        end
        e.bad = m_bad; e.ctx = m_ctx; e.ehi = m_ehi;
        sb.push_back(e);
        #1;
        check(tlb_req == mapped, {tag, " tlb_req R3"}, {31'b0, tlb_req}, {31'b0, mapped});
    endtask

    task automatic req(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] priv,
                       input logic el, input logic ie, input logic [2:0] tr, input logic [31:0] tpa,
                       input string tag);
        apply(va, kind, priv, el, ie, tr, tpa, 1'b0, 1'b0, 32'h0, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; sys_wr_en = 1'b0;
    endtask

    task automatic sys_write(input logic sel, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b0; sys_wr_en = 1'b1; sys_wr_sel = sel; sys_wr_data = data;
        if (sel) m_ehi = data; else m_ctx = data;
        @(negedge clk);
        sys_wr_en = 1'b0;
        check(context_reg == m_ctx, "R12 context write", context_reg, m_ctx);
        check(entry_hi == m_ehi, "R12 entry-high write", entry_hi, m_ehi);
    endtask

    // Monitor: compare each response against the queue front.
    always @(posedge clk) begin
        #1;
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_fault == e.fault, {e.tag, " fault"}, {31'b0, rsp_fault}, {31'b0, e.fault});
                check(rsp_paddr == e.pa, {e.tag, " paddr"}, rsp_paddr, e.pa);
                check(rsp_exc_code == e.code, {e.tag, " code"}, {27'b0, rsp_exc_code}, {27'b0, e.code});
                check(rsp_refill == e.refill, {e.tag, " refill R7"}, {31'b0, rsp_refill}, {31'b0, e.refill});
                check(rsp_inst_na == e.ina, {e.tag, " inst_na R9"}, {31'b0, rsp_inst_na}, {31'b0, e.ina});
                check(bad_vaddr == e.bad, {e.tag, " bad_vaddr R11"}, bad_vaddr, e.bad);
                check(context_reg == e.ctx, {e.tag, " context R11"}, context_reg, e.ctx);
                check(entry_hi == e.ehi, {e.tag, " entry_hi R11"}, entry_hi, e.ehi);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check(bad_vaddr == '0, "R1 bad_vaddr", bad_vaddr, 32'd0);
        check(context_reg == '0, "R1 context", context_reg, 32'd0);
        check(entry_hi == '0, "R1 entry_hi", entry_hi, 32'd0);
        rst_n = 1'b1;

        sys_write(1'b0, 32'hFFFF_FFFF);
        sys_write(1'b1, 32'h0000_00A5);
        check(tlb_asid == 8'hA5, "R12 tlb_asid", {24'b0, tlb_asid}, 32'hA5);

        // R2: error-level identity, lookup result ignored
        req(32'h1234_5678, 2'd0, 2'd2, 1'b1, 1'b0, 3'd1, 32'hDEAD_0000, "R2 identity");
        req(32'h7FFF_FFFF, 2'd1, 2'd0, 1'b1, 1'b0, 3'd3, 32'h0, "R2 top of region");
        // R3: mapped hits
        req(32'h0040_1000, 2'd0, 2'd2, 1'b0, 1'b0, 3'd0, 32'h1234_5000, "R3 user hit");
        req(32'hC000_0000, 2'd1, 2'd1, 1'b0, 1'b0, 3'd0, 32'h0ABC_0000, "R3 super region low");
        req(32'hDFFF_FFFF, 2'd2, 2'd0, 1'b0, 1'b0, 3'd0, 32'h0000_1FFF, "R3 super region high");
        req(32'hE000_0000, 2'd0, 2'd3, 1'b0, 1'b0, 3'd0, 32'h0555_0000, "R3 kernel top region");
        // R4: unmapped offsets
        req(32'h8123_4567, 2'd0, 2'd0, 1'b0, 1'b0, 3'd1, 32'h0, "R4 cached low");
        req(32'h9FFF_FFFF, 2'd1, 2'd0, 1'b0, 1'b0, 3'd1, 32'h0, "R4 cached edge");
        req(32'hA000_0010, 2'd2, 2'd3, 1'b0, 1'b0, 3'd1, 32'h0, "R4 uncached low");
        req(32'hBFFF_FFFF, 2'd0, 2'd0, 1'b0, 1'b0, 3'd1, 32'h0, "R4 uncached edge");
        // R5/R6: denied accesses
        req(32'h8000_1000, 2'd0, 2'd2, 1'b0, 1'b0, 3'd0, 32'h0, "R5 R6 user load cached");
        req(32'hA000_2000, 2'd1, 2'd1, 1'b0, 1'b0, 3'd0, 32'h0, "R5 R6 super store uncached");
        req(32'hC000_4000, 2'd2, 2'd2, 1'b0, 1'b0, 3'd0, 32'h0, "R5 R6 R9 user fetch super region");
        req(32'hF000_8000, 2'd1, 2'd1, 1'b0, 1'b0, 3'd0, 32'h0, "R5 R6 super store kernel region");
        // R7: miss and invalid
        req(32'h0040_3000, 2'd0, 2'd2, 1'b0, 1'b0, 3'd1, 32'h0, "R7 load miss");
        req(32'h0040_5000, 2'd1, 2'd2, 1'b0, 1'b0, 3'd1, 32'h0, "R7 store miss");
        req(32'h0040_7000, 2'd0, 2'd2, 1'b0, 1'b0, 3'd2, 32'h0, "R7 load invalid");
        req(32'hC040_9000, 2'd1, 2'd0, 1'b0, 1'b0, 3'd2, 32'h0, "R7 store invalid");
        req(32'h0041_0000, 2'd2, 2'd2, 1'b0, 1'b0, 3'd7, 32'h0, "R7 R9 reserved as miss fetch");
        // R8: clean page and inhibits
        req(32'h0042_0000, 2'd1, 2'd2, 1'b0, 1'b0, 3'd3, 32'h0, "R8 clean store");
        req(32'h0043_0000, 2'd2, 2'd2, 1'b0, 1'b1, 3'd4, 32'h0, "R8 R9 xinh enabled");
        req(32'h0044_0000, 2'd2, 2'd2, 1'b0, 1'b0, 3'd4, 32'h0, "R8 R9 xinh disabled");
        req(32'h0045_0000, 2'd0, 2'd2, 1'b0, 1'b1, 3'd5, 32'h0, "R8 rinh enabled");
        req(32'h0046_0000, 2'd0, 2'd2, 1'b0, 1'b0, 3'd5, 32'h0, "R8 rinh disabled");
        // R12: write collides with a fault (dropped), then with a success (kept)
        apply(32'h0047_E000, 2'd0, 2'd2, 1'b0, 1'b0, 3'd1, 32'h0, 1'b1, 1'b0, 32'h1234_5678, "R12 R11 fault beats write");
        apply(32'h8000_0000, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 32'h0, 1'b1, 1'b1, 32'hFFFF_FF3C, "R12 write with success");
        idle();
        check(tlb_asid == 8'h3C, "R12 tlb_asid after write", {24'b0, tlb_asid}, 32'h3C);
        req(32'hFFFF_E000, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0, 32'h0, "R11 R5 capture top address");
        idle();
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R10 all responses seen", sb.size(), 32'd0);
        check(rsp_valid == 1'b0, "R10 no response when idle", {31'b0, rsp_valid}, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule